// File: doc/BRIEF.md
# Command-Byte SPI Register Slave

This block lets an external SPI host reach a register file inside the chip. The host pulls chip select low and sends a command byte. The top bit of that byte selects a write or a read, and the low five bits select a register. A run of data bytes follows. How many data bytes follow depends on the register addressed, from one to three. On the register side the block presents an address, write data with a one-cycle write strobe, and a one-cycle read request with a read-data return.

The serial pins are asynchronous to the block. The block samples them with a fast system clock and finds the serial clock edges by comparing successive synchronized samples. It takes input bits on falling serial clock edges and moves the output on rising edges. The serial data output has a separate enable, which is high only while read data is being returned.

After the last data byte, the block waits for a new command within the same chip-select frame. Raising chip select at any point abandons the transfer. Addresses with no register behind them are still accepted: writes to them are dropped, and reads from them return zeros.

Top module: `spi_cmd_regslave`

## Requirements
- R1: Bits are taken only while csN is low. A rise of csN abandons any partial transfer, and the next frame starts again with a command byte.
- R2: Bit 7 of the command byte is 1 for a write and 0 for a read. Bits 4..0 are the register address. Bits 6 and 5 are ignored.
- R3: Addresses 0 to NUM_REGS-1 (0..23) are implemented and carry (address mod 3)+1 data bytes. Write data appears right-aligned and zero-extended on regWrData. Read data is taken from the low bytes of regRdData.
- R4: Data bytes travel most significant byte first, and each byte travels MSB first. DIN is captured at falling edges of SCLK. doutData changes after rising edges of SCLK, so it is valid when the host samples at the following falling edge.
- R5: doutEn is high from the first rising SCLK edge of a read data phase until the last data bit or a rise of csN. It is low during command bytes and writes, and it is low a few clock cycles after csN goes high.
- R6: For an implemented read, regRdReq pulses exactly once, after the command byte. The value returned to the host is the one captured at that pulse, even if the register changes later in the transfer.
- R7: regWrStb pulses for exactly one clock cycle after the final data bit of an implemented write. regAddr and regWrData are valid in that cycle.
- R8: No write strobe is issued when csN rises before the final data bit of a write.
- R9: Addresses NUM_REGS..31 carry one data byte. A write to them gives no strobe. A read from them gives no regRdReq and returns 0x00.
- R10: After the last data byte, the next byte in the same frame is treated as a new command.
- R11: Out of reset, doutEn, regWrStb and regRdReq are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCLK |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial data from the host |
| doutData | output | 1 | Serial read data toward the host |
| doutEn | output | 1 | High while doutData is driving |
| regAddr | output | 5 | Register address of the current command |
| regWrData | output | 24 | Write data, right-aligned |
| regWrStb | output | 1 | One-cycle write strobe |
| regRdReq | output | 1 | One-cycle read request |
| regRdData | input | 24 | Read data, valid in the regRdReq cycle |

## Verification
The checker watches every cycle for several properties:
- each strobe and each read request lasts exactly one cycle;
- neither reaches an unimplemented address;
- a strobe never follows a released chip select;
- the output enable drops once chip select has been high for a few cycles.

Other behaviour can only be shown by the bench's scenarios:
- byte counts per address;
- bit and byte order;
- data alignment;
- a snapshot read staying stable while the register changes;
- writes abandoned partway;
- a read and a write chained in one frame.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  typedef enum logic [1:0] {
    PH_CMD   = 2'd0,
    PH_WDATA = 2'd1,
    PH_RDATA = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic clrIn;
    logic loadOut;
    logic loadZero;
    logic shiftOut;
  } dp_ctrl_t;

  // data bytes carried by an address
  function automatic int unsigned bytesFor(input int unsigned addr,
                                           input int unsigned numRegs,
                                           input int unsigned maxBytes);
    return (addr < numRegs) ? (addr % maxBytes) + 1 : 1;
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic csN,
  input  logic sclk,
  input  logic din,
  output logic csAct,
  output logic sclkRise,
  output logic sclkFall,
  output logic dinS
);
  localparam int TOP = STAGES - 1;

  logic [STAGES-1:0] csQ, sclkQ, dinQ;
  logic sclkPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ      <= '1;
      sclkQ    <= '1;
      dinQ     <= '0;
      sclkPrev <= 1'b1;
    end else begin
      csQ      <= {csQ[TOP-1:0], csN};
      sclkQ    <= {sclkQ[TOP-1:0], sclk};
      dinQ     <= {dinQ[TOP-1:0], din};
      sclkPrev <= sclkQ[TOP];
    end
  end

  assign csAct    = ~csQ[TOP];
  assign sclkRise = sclkQ[TOP] & ~sclkPrev;
  assign sclkFall = ~sclkQ[TOP] & sclkPrev;
  assign dinS     = dinQ[TOP];
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int MAX_BYTES = 3,
  parameter int NUM_REGS  = 24,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csAct,
  input  logic              sclkRise,
  input  logic              sclkFall,
  input  logic              cmdWr,
  input  logic [ADDR_W-1:0] cmdAddr,
  output dp_ctrl_t          dp,
  output logic [LEN_W-1:0]  lenSel,
  output logic [ADDR_W-1:0] regAddr,
  output logic              regWrStb,
  output logic              regRdReq,
  output logic              doutEn
);
  localparam logic [ADDR_W:0] NUM_REGS_L = (ADDR_W + 1)'(NUM_REGS);

  phase_t             phase;
  logic [2:0]         bitCnt;
  logic [LEN_W-1:0]   byteCnt, nBytes;
  logic [ADDR_W-1:0]  addrQ;
  logic               hit, rdPend, wrStbQ, doutEnQ;

  logic               cmdDone, byteEnd, hitNext;
  logic [LEN_W-1:0]   lenNext;

  assign cmdDone = csAct && sclkFall && (phase == PH_CMD) && (bitCnt == 3'd7);
  assign byteEnd = sclkFall && (phase != PH_CMD) && (bitCnt == 3'd7);
  assign hitNext = {1'b0, cmdAddr} < NUM_REGS_L;
  assign lenNext = LEN_W'(bytesFor(int'(cmdAddr), NUM_REGS, MAX_BYTES));

  always_comb begin
    dp.shiftIn  = csAct && sclkFall && !cmdDone;
    dp.clrIn    = cmdDone || !csAct;
    dp.loadOut  = rdPend;
    dp.loadZero = !hit;
    dp.shiftOut = csAct && sclkRise && (phase == PH_RDATA);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_CMD;
      bitCnt  <= '0;
      byteCnt <= '0;
      nBytes  <= LEN_W'(1);
      addrQ   <= '0;
      hit     <= 1'b0;
      rdPend  <= 1'b0;
      wrStbQ  <= 1'b0;
      doutEnQ <= 1'b0;
    end else if (!csAct) begin
      phase   <= PH_CMD;
      bitCnt  <= '0;
      byteCnt <= '0;
      rdPend  <= 1'b0;
      wrStbQ  <= 1'b0;
      doutEnQ <= 1'b0;
    end else begin
      wrStbQ <= 1'b0;
      rdPend <= 1'b0;
      if (sclkFall) begin
        bitCnt <= bitCnt + 3'd1;
        if (cmdDone) begin
          addrQ   <= cmdAddr;
          hit     <= hitNext;
          nBytes  <= lenNext;
          byteCnt <= '0;
          phase   <= cmdWr ? PH_WDATA : PH_RDATA;
          rdPend  <= !cmdWr;
        end else if (byteEnd) begin
          if (byteCnt == nBytes - LEN_W'(1)) begin
            phase   <= PH_CMD;
            byteCnt <= '0;
            doutEnQ <= 1'b0;
            wrStbQ  <= (phase == PH_WDATA) && hit;
          end else begin
            byteCnt <= byteCnt + LEN_W'(1);
          end
        end
      end
      if (sclkRise && phase == PH_RDATA) doutEnQ <= 1'b1;
    end
  end

  assign lenSel   = nBytes;
  assign regAddr  = addrQ;
  assign regWrStb = wrStbQ;
  assign regRdReq = rdPend && hit;
  assign doutEn   = doutEnQ;
endmodule

// File: rtl/spi_dpath.sv
module spi_dpath
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int MAX_BYTES = 3,
  localparam int DATA_W   = 8 * MAX_BYTES,
  localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_ctrl_t          dp,
  input  logic [LEN_W-1:0]  lenSel,
  input  logic              dinS,
  input  logic [DATA_W-1:0] regRdData,
  output logic              cmdWr,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              doutData
);
  logic [DATA_W-1:0] shIn, shOut, inNext, alignedRd;
  logic              doutQ;

  assign inNext  = {shIn[DATA_W-2:0], dinS};
  assign cmdWr   = inNext[7];
  assign cmdAddr = inNext[ADDR_W-1:0];

  // left-align the returned bytes so the first byte leaves first
  always_comb begin
    alignedRd = regRdData << (8 * (MAX_BYTES - int'(lenSel)));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shIn  <= '0;
      shOut <= '0;
      doutQ <= 1'b0;
    end else begin
      if (dp.clrIn)        shIn <= '0;
      else if (dp.shiftIn) shIn <= inNext;

      if (dp.loadOut) begin
        shOut <= dp.loadZero ? '0 : alignedRd;
      end else if (dp.shiftOut) begin
        doutQ <= shOut[DATA_W-1];
        shOut <= {shOut[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign regWrData = shIn;
  assign doutData  = doutQ;
endmodule

// File: rtl/spi_cmd_regslave.sv
module spi_cmd_regslave
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int MAX_BYTES   = 3,
  parameter int NUM_REGS    = 24,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = 8 * MAX_BYTES,
  localparam int LEN_W      = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  output logic              doutData,
  output logic              doutEn,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              regWrStb,
  output logic              regRdReq,
  input  logic [DATA_W-1:0] regRdData
);
  logic csAct, sclkRise, sclkFall, dinS, cmdWr;
  logic [ADDR_W-1:0] cmdAddr;
  logic [LEN_W-1:0]  lenSel;
  dp_ctrl_t dp;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .csAct(csAct), .sclkRise(sclkRise), .sclkFall(sclkFall), .dinS(dinS)
  );

  spi_ctrl #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES), .NUM_REGS(NUM_REGS)) uCtrl (
    .clk(clk), .rstN(rstN), .csAct(csAct), .sclkRise(sclkRise),
    .sclkFall(sclkFall), .cmdWr(cmdWr), .cmdAddr(cmdAddr), .dp(dp),
    .lenSel(lenSel), .regAddr(regAddr), .regWrStb(regWrStb),
    .regRdReq(regRdReq), .doutEn(doutEn)
  );

  spi_dpath #(.ADDR_W(ADDR_W), .MAX_BYTES(MAX_BYTES)) uDpath (
    .clk(clk), .rstN(rstN), .dp(dp), .lenSel(lenSel), .dinS(dinS),
    .regRdData(regRdData), .cmdWr(cmdWr), .cmdAddr(cmdAddr),
    .regWrData(regWrData), .doutData(doutData)
  );
endmodule

// File: rtl/spi_cmd_regslave_chk.sv
module spi_cmd_regslave_chk #(
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              doutEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrStb,
  input logic              regRdReq
);
  // R7: strobe is a single cycle
  a_r7_stb_single: assert property (@(posedge clk) disable iff (!rstN)
    regWrStb |=> !regWrStb);

  // R6: read request is a single cycle
  a_r6_rdreq_single: assert property (@(posedge clk) disable iff (!rstN)
    regRdReq |=> !regRdReq);

  // R9: no strobe toward an unimplemented address
  a_r9_stb_implemented: assert property (@(posedge clk) disable iff (!rstN)
    regWrStb |-> (int'(regAddr) < NUM_REGS));

  // R9: no read request toward an unimplemented address
  a_r9_rdreq_implemented: assert property (@(posedge clk) disable iff (!rstN)
    regRdReq |-> (int'(regAddr) < NUM_REGS));

  // R5: output enable low once chip select has been high a while
  a_r5_en_idle: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !doutEn);

  // R8: a strobe only follows a frame still selected
  a_r8_stb_in_frame: assert property (@(posedge clk) disable iff (!rstN)
    regWrStb |-> !$past(csN, 3));
endmodule

bind spi_cmd_regslave spi_cmd_regslave_chk #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .doutEn(doutEn), .regAddr(regAddr),
  .regWrStb(regWrStb), .regRdReq(regRdReq)
);

// File: tb/sim_spi_cmd_regslave.sv
`timescale 1ns/1ps
module sim_spi_cmd_regslave;
  localparam int H = 6;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b1, din = 1'b0;
  logic doutData, doutEn, regWrStb, regRdReq;
  logic [4:0]  regAddr;
  logic [23:0] regWrData, regRdData;

  logic [23:0] model  [32];
  logic [23:0] refReg [32];
  int total = 0, fails = 0, stbCount = 0, rdCount = 0;
  logic [4:0]  lastAddr;
  logic [23:0] lastData;

  always #2.5 clk = ~clk;

  spi_cmd_regslave u0 (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din),
    .doutData(doutData), .doutEn(doutEn), .regAddr(regAddr),
    .regWrData(regWrData), .regWrStb(regWrStb), .regRdReq(regRdReq),
    .regRdData(regRdData)
  );

  assign regRdData = model[regAddr];

  always @(posedge clk) begin
    if (regWrStb) begin
      model[regAddr] <= regWrData;
      stbCount = stbCount + 1;
      lastAddr = regAddr;
      lastData = regWrData;
    end
    if (regRdReq) rdCount = rdCount + 1;
  end

  function automatic int expBytes(input logic [4:0] a);
    return (a < 24) ? (int'(a) % 3) + 1 : 1;
  endfunction

  function automatic logic [23:0] expMask(input logic [4:0] a);
    return 24'((32'd1 << (8 * expBytes(a))) - 1);
  endfunction

  function automatic logic [23:0] expRead(input logic [4:0] a);
    return (a < 24) ? (refReg[a] & expMask(a)) : 24'h0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output logic [7:0] r, output bit enAll, output bit enAny);
    enAll = 1'b1; enAny = 1'b0; r = '0;
    for (int i = 7; i >= 0; i--) begin
      din = b[i];
      repeat (H) @(negedge clk);
      r[i] = doutData;
      enAll &= doutEn;
      enAny |= doutEn;
      sclk = 1'b0;
      repeat (H) @(negedge clk);
      sclk = 1'b1;
    end
  endtask

  task automatic csLow();
    csN = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic csHigh();
    repeat (H) @(negedge clk);
    csN = 1'b1;
    repeat (2 * H) @(negedge clk);
  endtask

  task automatic writeBody(input logic [4:0] a, input logic [23:0] v, output bit enSeen);
    logic [7:0] r; bit ea, en;
    sendByte({3'b100, a}, r, ea, en);
    enSeen = en;
    for (int k = expBytes(a) - 1; k >= 0; k--) begin
      sendByte(v[8*k +: 8], r, ea, en);
      enSeen |= en;
    end
    if (a < 24) refReg[a] = v & expMask(a);
  endtask

  task automatic readBody(input logic [7:0] cmd, input bit corrupt, output logic [23:0] v, output bit enOk);
    logic [7:0] r; bit ea, en;
    sendByte(cmd, r, ea, en);
    enOk = !en;
    if (corrupt) model[cmd[4:0]] = ~model[cmd[4:0]];
    v = '0;
    for (int k = 0; k < expBytes(cmd[4:0]); k++) begin
      sendByte(8'h00, r, ea, en);
      v = {v[15:0], r};
      enOk &= ea;
    end
  endtask

  initial begin
    logic [23:0] v, val;
    logic [4:0] a;
    bit enOk, enSeen;
    int s0, r0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) begin
      model[i]  = 24'($urandom);
      refReg[i] = model[i];
    end
    repeat (5) @(negedge clk);
    // R11: reset state
    chk(doutEn == 1'b0, "R11 doutEn", doutEn, 0);
    chk(regWrStb == 1'b0, "R11 regWrStb", regWrStb, 0);
    chk(regRdReq == 1'b0, "R11 regRdReq", regRdReq, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R3/R4: directed bit/byte order on a 3-byte register
    s0 = stbCount;
    csLow(); writeBody(5'd2, 24'h800001, enSeen); csHigh();
    chk(stbCount == s0 + 1, "R7 strobe count", stbCount, s0 + 1);
    chk(lastData == 24'h800001, "R4 write order", lastData, 24'h800001);
    chk(enSeen == 1'b0, "R5 doutEn low in write", enSeen, 0);
    r0 = rdCount;
    csLow(); readBody({3'b000, 5'd2}, 1'b0, v, enOk); csHigh();
    chk(v == 24'h800001, "R4 read order", v, 24'h800001);
    chk(enOk, "R5 doutEn during read", enOk, 1);
    chk(rdCount == r0 + 1, "R6 single read request", rdCount, r0 + 1);
    chk(doutEn == 1'b0, "R5 doutEn after csN high", doutEn, 0);

    // random writes then read-backs
    for (int it = 0; it < 30; it++) begin
      a = 5'($urandom % 32);
      val = 24'($urandom);
      s0 = stbCount;
      csLow(); writeBody(a, val, enSeen); csHigh();
      chk(stbCount == s0 + ((a < 24) ? 1 : 0), "R7/R9 strobe count", stbCount, s0 + ((a < 24) ? 1 : 0));
      if (a < 24) begin
        chk(lastAddr == a, "R7 strobe address", lastAddr, a);
        chk(lastData == (val & expMask(a)), "R3 write data", lastData, val & expMask(a));
      end
      r0 = rdCount;
      csLow(); readBody({3'b000, a}, 1'b0, v, enOk); csHigh();
      chk(v == expRead(a), "R3/R9 read data", v, expRead(a));
      chk(enOk, "R5 doutEn window", enOk, 1);
      chk(rdCount == r0 + ((a < 24) ? 1 : 0), "R6/R9 read request", rdCount, r0 + ((a < 24) ? 1 : 0));
    end

    // R9: unimplemented read returns zero though the model holds a value
    model[31] = 24'hABCDEF;
    r0 = rdCount;
    csLow(); readBody({3'b000, 5'd31}, 1'b0, v, enOk); csHigh();
    chk(v == 24'h0, "R9 unimplemented read", v, 0);
    chk(rdCount == r0, "R9 no read request", rdCount, r0);

    // R8/R1: abandoned write
    s0 = stbCount;
    csLow();
    begin
      logic [7:0] r; bit ea, en;
      sendByte(8'h82, r, ea, en);
      sendByte(8'h5A, r, ea, en);
    end
    csHigh();
    chk(stbCount == s0, "R8 no strobe on abort", stbCount, s0);
    csLow(); readBody({3'b000, 5'd2}, 1'b0, v, enOk); csHigh();
    chk(v == expRead(5'd2), "R1 register kept after abort", v, expRead(5'd2));

    // R6: snapshot stays stable while the register changes
    csLow(); readBody({3'b000, 5'd4}, 1'b1, v, enOk); csHigh();
    chk(v == expRead(5'd4), "R6 snapshot read", v, expRead(5'd4));
    model[4] = refReg[4];

    // R10: write then read in a single frame
    s0 = stbCount;
    csLow();
    writeBody(5'd5, 24'h3C5AA5, enSeen);
    readBody({3'b000, 5'd5}, 1'b0, v, enOk);
    csHigh();
    chk(stbCount == s0 + 1, "R10 chained write", stbCount, s0 + 1);
    chk(v == 24'h3C5AA5, "R10 chained read", v, 24'h3C5AA5);

    // R2: bits 6 and 5 ignored on a read
    s0 = stbCount;
    csLow(); readBody({3'b011, 5'd8}, 1'b0, v, enOk); csHigh();
    chk(v == expRead(5'd8), "R2 read with bits 6:5 set", v, expRead(5'd8));
    chk(stbCount == s0, "R2 no strobe on read", stbCount, s0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired actual=%0d expected=done", total);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule